// File: doc/BRIEF.md
# E1 Spare-Bit and E-Bit Source Selector

This block produces the value sent in bit 1 of time slot 0 for each outgoing E1 frame. The transmit framer raises a request once per frame and gives the frame's position (0 to 15) in the multiframe. Even positions are frames that carry the frame alignment signal; odd positions are frames that do not. The block answers on the next clock with the bit to send, and holds that bit until the next request.

Without CRC-4, the bit comes either from two register bits (one for alignment frames, one for non-alignment frames) or from the system data stream. With CRC-4, positions 13 and 15 carry the E bits. All other positions carry either the CRC bit supplied by the CRC generator or the fixed multiframe alignment pattern.

E bits are driven to 0 for one of three reasons:
- a forced rule while receive multiframe alignment is lost;
- one-shot requests made by register writes;
- errored-submultiframe reports from the receiver.

One-shot requests and errored-submultiframe reports are held in saturating backlog counters, so that a burst of reports is not lost.

Top module: `e1_spare_bit_src`

## Requirements
- R1: With `crc4_en_i`=0 and `ctrl_i[0]`=1, an even frame sends `ctrl_i[1]` and an odd frame sends `ctrl_i[2]`.
- R2: With `crc4_en_i`=0 and `ctrl_i[0]`=0, every frame sends `sys_si_i`.
- R3: With `crc4_en_i`=1, even frames send `crc_bit_i`. Odd frames 1, 3, 5, 7, 9, 11 send 0, 0, 1, 0, 1, 1 in that order.
- R4: With `crc4_en_i`=1 and `ctrl_i[0]`=0, when no zero is pending or forced, frame 13 sends `ctrl_i[1]` and frame 15 sends `ctrl_i[2]`.
- R5: With `crc4_en_i`=1 and `ctrl_i[0]`=1, each cycle with `wr_strobe_i`=1 and `wr_tsi_i[0]`=0 queues one E=0 for frame 13. The same condition with `wr_tsi_i[1]`=0 queues one E=0 for frame 15. Each queue saturates at 2^CNT_W-1 entries, and one entry is used per matching E slot.
- R6: While `ctrl_i[3]`=1, each `smf_err_i` pulse queues one E=0 (saturating). Each queue entry is used by the next E slot (13 or 15) that no one-shot zero claims.
- R7: With `ctrl_i[4]`=1, both E bits are 0 while `mf_lost_i` or `lof_i` is 1. Loss of frame alignment counts as loss of multiframe alignment.
- R8: With `ctrl_i[5]`=1, both E bits are 0 while `tmr_exp_i`=1 and multiframe alignment is lost.
- R9: Rule priority is: forced zeros first, then one-shot zeros, then errored-submultiframe zeros, then the default. The default is 1 when `ctrl_i[0]`=1. While a forced zero is sent, no queued entry is used.
- R10: `tx_bit_o` updates only on the clock after `bit_req_i`=1 and otherwise holds its value. Reset sets it to 1 and empties both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_req_i | input | 1 | Request for bit 1 of time slot 0 of the current frame |
| frame_num_i | input | 4 | Frame position in the multiframe, 0 to 15 |
| crc4_en_i | input | 1 | CRC-4 multiframe mode |
| ctrl_i | input | 6 | Control register contents |
| wr_strobe_i | input | 1 | Write to the two spare-bit register fields |
| wr_tsi_i | input | 2 | Values being written: [0] for frame 13 / alignment frames, [1] for frame 15 / other frames |
| sys_si_i | input | 1 | Spare bit taken from system data |
| crc_bit_i | input | 1 | CRC bit for even frames in CRC-4 mode |
| smf_err_i | input | 1 | Pulse: received errored CRC-4 submultiframe |
| mf_lost_i | input | 1 | Receive CRC-4 multiframe alignment lost |
| lof_i | input | 1 | Receive frame alignment lost |
| tmr_exp_i | input | 1 | Multiframe search timer expired |
| tx_bit_o | output | 1 | Bit to transmit |

## Verification
The bench fills the one-shot queue past its limit. A design that wraps instead of saturating would send too few zeros. It also queues zeros, forces zeros during loss of alignment, and then releases the loss. A design that drained the queues during forced slots would send 1 too early after the release. It sends errored-submultiframe reports on the same cycle as an E slot that uses one. A design that let one cancel the other would lose or duplicate a zero. It drives loss of frame alignment with multiframe loss low, to catch a design that ignores the implied multiframe loss.

// File: rtl/e1sb_pkg.sv
package e1sb_pkg;
  localparam int unsigned FN_W   = 4;
  localparam int unsigned N_ESLT = 2;
  localparam logic [FN_W-1:0] FN_E0 = 4'd13;
  localparam logic [FN_W-1:0] FN_E1 = 4'd15;

  // multiframe alignment pattern on odd frames 1..11
  function automatic logic mfas_bit(input logic [FN_W-1:0] fn);
    logic b;
    case (fn)
      4'd5, 4'd9, 4'd11: b = 1'b1;
      default:           b = 1'b0;
    endcase
    return b;
  endfunction

  function automatic logic is_e_slot(input logic [FN_W-1:0] fn);
    return (fn == FN_E0) || (fn == FN_E1);
  endfunction
endpackage

// File: rtl/e1sb_sat_counter.sv
module e1sb_sat_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;  // simultaneous inc and dec cancel
      endcase
    end
  end

  assign nz_o = (cnt_q != '0);
endmodule

// File: rtl/e1sb_e_arbiter.sv
module e1sb_e_arbiter (
  input  logic force_i,
  input  logic man_mode_i,
  input  logic man_val_i,
  input  logic os_pend_i,
  input  logic smf_pend_i,
  output logic e_bit_o,
  output logic take_os_o,
  output logic take_smf_o
);
  always_comb begin
    e_bit_o    = 1'b1;
    take_os_o  = 1'b0;
    take_smf_o = 1'b0;
    if (force_i) begin
      e_bit_o = 1'b0;
    end else if (!man_mode_i && os_pend_i) begin
      e_bit_o   = 1'b0;
      take_os_o = 1'b1;
    end else if (smf_pend_i) begin
      e_bit_o    = 1'b0;
      take_smf_o = 1'b1;
    end else begin
      e_bit_o = man_mode_i ? man_val_i : 1'b1;
    end
  end
endmodule

// File: rtl/e1_spare_bit_src.sv
module e1_spare_bit_src
  import e1sb_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_req_i,
  input  logic [FN_W-1:0] frame_num_i,
  input  logic            crc4_en_i,
  input  logic [5:0]      ctrl_i,
  input  logic            wr_strobe_i,
  input  logic [1:0]      wr_tsi_i,
  input  logic            sys_si_i,
  input  logic            crc_bit_i,
  input  logic            smf_err_i,
  input  logic            mf_lost_i,
  input  logic            lof_i,
  input  logic            tmr_exp_i,
  output logic            tx_bit_o
);
  logic              reg_mode;
  logic              mf_lost_eff;
  logic              force_zero;
  logic              e_slot;
  logic              slot_sel;
  logic              e_act;
  logic [N_ESLT-1:0] os_nz;
  logic              smf_nz;
  logic              e_bit;
  logic              take_os;
  logic              take_smf;
  logic              next_bit;
  logic              bit_q;

  assign reg_mode    = ctrl_i[0];
  assign mf_lost_eff = mf_lost_i | lof_i;  // frame loss implies multiframe loss
  assign force_zero  = mf_lost_eff & (ctrl_i[4] | (ctrl_i[5] & tmr_exp_i));
  assign e_slot      = is_e_slot(frame_num_i);
  assign slot_sel    = (frame_num_i == FN_E1);
  assign e_act       = bit_req_i & crc4_en_i & e_slot;

  for (genvar g = 0; g < N_ESLT; g++) begin : g_os
    logic inc, dec;
    assign inc = wr_strobe_i & crc4_en_i & reg_mode & ~wr_tsi_i[g];
    assign dec = e_act & take_os & (slot_sel == 1'(g));
    e1sb_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc),
      .dec_i (dec),
      .nz_o  (os_nz[g])
    );
  end

  e1sb_sat_counter #(.CNT_W(CNT_W)) u_smf_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (smf_err_i & ctrl_i[3]),
    .dec_i (e_act & take_smf),
    .nz_o  (smf_nz)
  );

  e1sb_e_arbiter u_arb (
    .force_i   (force_zero),
    .man_mode_i(~reg_mode),
    .man_val_i (slot_sel ? ctrl_i[2] : ctrl_i[1]),
    .os_pend_i (os_nz[slot_sel]),
    .smf_pend_i(smf_nz & ctrl_i[3]),
    .e_bit_o   (e_bit),
    .take_os_o (take_os),
    .take_smf_o(take_smf)
  );

  always_comb begin
    if (!crc4_en_i)
      next_bit = reg_mode ? (frame_num_i[0] ? ctrl_i[2] : ctrl_i[1]) : sys_si_i;
    else if (!e_slot)
      next_bit = frame_num_i[0] ? mfas_bit(frame_num_i) : crc_bit_i;
    else
      next_bit = e_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bit_q <= 1'b1;
    else if (bit_req_i) bit_q <= next_bit;
  end

  assign tx_bit_o = bit_q;
endmodule

// File: rtl/e1sb_checker.sv
module e1sb_checker
  import e1sb_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bit_req_i,
  input logic [FN_W-1:0] frame_num_i,
  input logic            crc4_en_i,
  input logic [5:0]      ctrl_i,
  input logic            sys_si_i,
  input logic            crc_bit_i,
  input logic            mf_lost_i,
  input logic            lof_i,
  input logic            tmr_exp_i,
  input logic [1:0]      os_pend_i,
  input logic            smf_pend_i,
  input logic            tx_bit_o
);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_req_i |=> $stable(tx_bit_o));

  assert_reg_mode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_i && !crc4_en_i && ctrl_i[0] |=>
      tx_bit_o == ($past(frame_num_i[0]) ? $past(ctrl_i[2]) : $past(ctrl_i[1])));

  assert_sys_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_i && !crc4_en_i && !ctrl_i[0] |=> tx_bit_o == $past(sys_si_i));

  assert_crc_even_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_i && crc4_en_i && !frame_num_i[0] |=> tx_bit_o == $past(crc_bit_i));

  assert_mfas_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_i && crc4_en_i && frame_num_i[0] && !is_e_slot(frame_num_i) |=>
      tx_bit_o == mfas_bit($past(frame_num_i)));

  assert_force_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_i && crc4_en_i && is_e_slot(frame_num_i) && ctrl_i[4] &&
    (mf_lost_i || lof_i) |=> !tx_bit_o);

  assert_timer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_i && crc4_en_i && is_e_slot(frame_num_i) && ctrl_i[5] && tmr_exp_i &&
    (mf_lost_i || lof_i) |=> !tx_bit_o);

  assert_default_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_i && crc4_en_i && is_e_slot(frame_num_i) && ctrl_i[0] &&
    !((mf_lost_i || lof_i) && (ctrl_i[4] || (ctrl_i[5] && tmr_exp_i))) &&
    !os_pend_i[frame_num_i == FN_E1] && !(ctrl_i[3] && smf_pend_i) |=> tx_bit_o);
endmodule

bind e1_spare_bit_src e1sb_checker u_e1sb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_req_i  (bit_req_i),
  .frame_num_i(frame_num_i),
  .crc4_en_i  (crc4_en_i),
  .ctrl_i     (ctrl_i),
  .sys_si_i   (sys_si_i),
  .crc_bit_i  (crc_bit_i),
  .mf_lost_i  (mf_lost_i),
  .lof_i      (lof_i),
  .tmr_exp_i  (tmr_exp_i),
  .os_pend_i  (os_nz),
  .smf_pend_i (smf_nz),
  .tx_bit_o   (tx_bit_o)
);

// File: tb/tb_e1_spare_bit_src.sv
module tb_e1_spare_bit_src;
  localparam int CNT_W = 3;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_req_i = 1'b0;
  logic [3:0] frame_num_i = '0;
  logic       crc4_en_i = 1'b0;
  logic [5:0] ctrl_i = '0;
  logic       wr_strobe_i = 1'b0;
  logic [1:0] wr_tsi_i = '1;
  logic       sys_si_i = 1'b0;
  logic       crc_bit_i = 1'b0;
  logic       smf_err_i = 1'b0;
  logic       mf_lost_i = 1'b0;
  logic       lof_i = 1'b0;
  logic       tmr_exp_i = 1'b0;
  logic       tx_bit_o;

  int n_chk = 0;
  int n_err = 0;
  int os_m[2];
  int smf_m;
  logic last_o;

  always #4 clk_i = ~clk_i;

  e1_spare_bit_src #(.CNT_W(CNT_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_req_i(bit_req_i), .frame_num_i(frame_num_i),
    .crc4_en_i(crc4_en_i), .ctrl_i(ctrl_i), .wr_strobe_i(wr_strobe_i), .wr_tsi_i(wr_tsi_i),
    .sys_si_i(sys_si_i), .crc_bit_i(crc_bit_i), .smf_err_i(smf_err_i),
    .mf_lost_i(mf_lost_i), .lof_i(lof_i), .tmr_exp_i(tmr_exp_i), .tx_bit_o(tx_bit_o)
  );

  function automatic logic pat_bit(input int f);
    return (f == 5 || f == 9 || f == 11);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s frame=%0d actual=%b expected=%b", req, frame_num_i, act, exp);
    end
  endtask

  // one clock: model from current inputs, then check after the edge
  task automatic step();
    logic e, mfl, frc, tos, tsm, was_req;
    int sl;
    string tag;
    e = 1'b1; tos = 1'b0; tsm = 1'b0; tag = "R10";
    sl = (frame_num_i == 4'd15) ? 1 : 0;
    mfl = mf_lost_i | lof_i;
    frc = mfl & (ctrl_i[4] | (ctrl_i[5] & tmr_exp_i));
    was_req = bit_req_i;
    if (bit_req_i) begin
      if (!crc4_en_i) begin
        tag = ctrl_i[0] ? "R1" : "R2";
        e = ctrl_i[0] ? (frame_num_i[0] ? ctrl_i[2] : ctrl_i[1]) : sys_si_i;
      end else if (frame_num_i != 4'd13 && frame_num_i != 4'd15) begin
        tag = "R3";
        e = frame_num_i[0] ? pat_bit(int'(frame_num_i)) : crc_bit_i;
      end else if (frc) begin
        tag = (ctrl_i[4] && mfl) ? "R7" : "R8";
        e = 1'b0;
      end else if (ctrl_i[0] && os_m[sl] > 0) begin
        tag = "R5"; e = 1'b0; tos = 1'b1;
      end else if (ctrl_i[3] && smf_m > 0) begin
        tag = "R6"; e = 1'b0; tsm = 1'b1;
      end else begin
        tag = ctrl_i[0] ? "R9" : "R4";
        e = ctrl_i[0] ? 1'b1 : (sl == 1 ? ctrl_i[2] : ctrl_i[1]);
      end
    end
    for (int g = 0; g < 2; g++) begin
      logic inc, dec;
      inc = wr_strobe_i & crc4_en_i & ctrl_i[0] & ~wr_tsi_i[g];
      dec = tos && (sl == g);
      if (inc && !dec && os_m[g] < CMAX) os_m[g]++;
      else if (dec && !inc) os_m[g]--;
    end
    begin
      logic inc;
      inc = smf_err_i & ctrl_i[3];
      if (inc && !tsm && smf_m < CMAX) smf_m++;
      else if (tsm && !inc) smf_m--;
    end
    @(posedge clk_i);
    #2;
    if (was_req) check(tag, tx_bit_o, e);
    else         check("R10", tx_bit_o, last_o);
    last_o = tx_bit_o;
    if (was_req) frame_num_i = frame_num_i + 4'd1;
  endtask

  task automatic idle_inputs();
    bit_req_i = 1'b0; wr_strobe_i = 1'b0; wr_tsi_i = 2'b11; smf_err_i = 1'b0;
  endtask

  // run n requested frames with quiet side inputs
  task automatic run_frames(input int n);
    for (int i = 0; i < n; i++) begin
      idle_inputs();
      bit_req_i = 1'b1;
      step();
    end
    idle_inputs();
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1947));
    os_m = '{0, 0};
    smf_m = 0;
    repeat (3) @(posedge clk_i);
    #2;
    check("R10", tx_bit_o, 1'b1);  // reset value
    rst_ni = 1'b1;
    last_o = 1'b1;

    // R5: overfill frame-13 one-shot queue, expect CMAX zeros in frame 13
    crc4_en_i = 1'b1; ctrl_i = 6'b000001; frame_num_i = '0;
    for (int i = 0; i < CMAX + 3; i++) begin
      idle_inputs(); wr_strobe_i = 1'b1; wr_tsi_i = 2'b10; step();
    end
    run_frames(16 * (CMAX + 2));

    // R9: queue smf reports, hold them through forced loss (R7), then drain
    ctrl_i = 6'b011001; mf_lost_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      idle_inputs(); smf_err_i = 1'b1; step();
    end
    run_frames(32);
    mf_lost_i = 1'b0;
    run_frames(48);

    // R7: frame loss alone forces E bits
    lof_i = 1'b1; run_frames(32); lof_i = 1'b0;

    // R8: timer rule
    ctrl_i = 6'b100001; mf_lost_i = 1'b1; tmr_exp_i = 1'b1; run_frames(16);
    tmr_exp_i = 1'b0; run_frames(16); mf_lost_i = 1'b0;

    // R6: smf pulse coinciding with an E slot that consumes one
    ctrl_i = 6'b001001; frame_num_i = 4'd0;
    idle_inputs(); smf_err_i = 1'b1; step();
    run_frames(13);
    idle_inputs(); bit_req_i = 1'b1; smf_err_i = 1'b1; step();
    run_frames(34);

    // random phases: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int ph = 0; ph < 8; ph++) begin
      crc4_en_i = ph[0];
      for (int c = 0; c < 1500; c++) begin
        bit_req_i   = ($urandom % 3) != 0;
        wr_strobe_i = ($urandom % 10) == 0;
        wr_tsi_i    = 2'($urandom);
        smf_err_i   = ($urandom % 8) == 0;
        sys_si_i    = 1'($urandom);
        crc_bit_i   = 1'($urandom);
        if ($urandom % 50 == 0) ctrl_i = 6'($urandom);
        if ($urandom % 40 == 0) mf_lost_i = ($urandom % 4) == 0;
        if ($urandom % 60 == 0) lof_i = ($urandom % 6) == 0;
        if ($urandom % 40 == 0) tmr_exp_i = 1'($urandom);
        step();
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule